// File: doc/BRIEF.md
# Directory Coherence Controller for Four Caches

This block is the central bookkeeper of a small shared-memory cluster. For each tracked memory line it holds a line state (uncached, shared, or exclusively owned) and a bit-vector with one bit per cache. Caches send it two kinds of request: a read miss, and a request for the right to write. The controller works out who else holds the line and sends invalidate or write-back commands to those caches. It collects their acknowledgements, drives read or write commands to main memory when the data there must be fetched or refreshed, and finally answers the requester with a grant.

One transaction is in flight at a time. While it runs, every new request is refused in the same cycle with a retry indication, and the directory is left untouched by it. The requesting cache tries again later. An exclusive grant is only issued once every other holder has confirmed that its copy is gone. A read miss on a line owned by another cache first makes that owner push its copy back to memory, and the line then ends up shared by both.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every line is uncached with an empty sharer set, and `rsp_valid`, `snp_valid`, `mem_rd`, `mem_wr` and `req_nack` are low.
- R2: A read miss (`req_excl`=0) on an uncached or shared line raises `mem_rd` for `mem_line` and holds it until `mem_done`; in the next cycle a one-cycle grant with `rsp_code`=2'b01 (shared) is given, and the requester is added to the line's sharer set, which bit i of every mask represents cache i.
- R3: An exclusive request (`req_excl`=1) from the only holder of a shared line, or from the current owner, is granted in the cycle after acceptance with `rsp_code`=2'b10, with no snoop command and no memory access.
- R4: An exclusive request on a shared line with other holders produces a one-cycle snoop command with `snp_wb`=0 (invalidate) and `snp_mask` equal to exactly those other holders; the grant is withheld until every cache in that mask has pulsed its `ack_valid` bit, and acknowledgements from caches outside the mask have no effect.
- R5: When invalidation finishes and the requester held no copy, a memory read is performed before the exclusive grant.
- R6: A read miss on a line owned by another cache issues a snoop command with `snp_wb`=1 (write-back) addressed to the owner only, waits for its acknowledgement, then raises `mem_wr` until `mem_done`, then grants shared; the sharer set becomes the former owner plus the reader.
- R7: An exclusive request on a line owned by another cache issues the same write-back, acknowledgement and memory write sequence, then grants exclusive; the requester becomes the sole recorded holder.
- R8: An exclusive request on an uncached line performs a memory read and then grants exclusive.
- R9: While a transaction is in progress, any request raises `req_nack` in the same cycle and is dropped without changing any line's directory entry.
- R10: An uncached line has an empty sharer set, a shared line a non-empty one, and an owned line exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A cache presents a request this cycle |
| req_src | input | CW | Requesting cache number |
| req_line | input | LW | Directory line index of the request |
| req_excl | input | 1 | 0 = read miss, 1 = request for write ownership |
| req_nack | output | 1 | Request refused this cycle, retry later |
| ack_valid | input | NC | Per-cache acknowledgement pulse for a snoop command |
| snp_valid | output | 1 | One-cycle snoop command |
| snp_wb | output | 1 | 0 = invalidate, 1 = write back and invalidate |
| snp_mask | output | NC | Caches addressed by the snoop command |
| snp_line | output | LW | Line the snoop command refers to |
| mem_rd | output | 1 | Memory read request, held until `mem_done` |
| mem_wr | output | 1 | Memory write request, held until `mem_done` |
| mem_line | output | LW | Line for the memory request |
| mem_done | input | 1 | Memory finished the current request |
| rsp_valid | output | 1 | One-cycle grant to the requester |
| rsp_dst | output | CW | Cache receiving the grant |
| rsp_line | output | LW | Line being granted |
| rsp_code | output | 2 | 2'b01 shared grant, 2'b10 exclusive grant |

## Verification
The assertions assume that caches only acknowledge in answer to a snoop command, that `mem_done` arrives only while `mem_rd` or `mem_wr` is high, and that requesters respect `req_nack` by retrying instead of assuming acceptance. The stimulus keeps to these rules: the bench plays both the caches and memory, answers each command only after seeing it at the ports, and sends stray acknowledgements and competing requests only in the middle of a snoop wait, where the block must ignore or refuse them. A behavioural model of the directory held in integer arrays predicts the command, memory and grant pattern of each transaction, and the bench compares the outputs against it on every cycle of the transaction.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    LN_UNC = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_INV  = 3'd1,
    PH_WB   = 3'd2,
    PH_MWR  = 3'd3,
    PH_MRD  = 3'd4,
    PH_RESP = 3'd5
  } phase_e;

  localparam logic [1:0] RSP_SHARED = 2'b01;
  localparam logic [1:0] RSP_EXCL   = 2'b10;

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
  import coh_dir_pkg::*;
#(
  parameter int NC = 4,
  parameter int NL = 4,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_line,
  output line_st_e      rd_st,
  output logic [NC-1:0] rd_mask,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_line,
  input  line_st_e      wr_st,
  input  logic [NC-1:0] wr_mask
);

  line_st_e      st_q   [NL];
  logic [NC-1:0] mask_q [NL];

  for (genvar g = 0; g < NL; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= LN_UNC;
        mask_q[g] <= '0;
      end else if (wr_en && wr_line == LW'(g)) begin
        st_q[g]   <= wr_st;
        mask_q[g] <= wr_mask;
      end
    end

    assert_unc_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == LN_UNC) |-> (mask_q[g] == '0));
    assert_shr_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == LN_SHR) |-> (mask_q[g] != '0));
    assert_exc_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == LN_EXC) |-> $onehot(mask_q[g]));
  end

  assign rd_st   = st_q[rd_line];
  assign rd_mask = mask_q[rd_line];

endmodule

// File: rtl/coh_ack_tracker.sv
module coh_ack_tracker #(
  parameter int NC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NC-1:0] load_mask,
  input  logic [NC-1:0] ack_valid,
  output logic [NC-1:0] pend,
  output logic          all_done
);

  always_ff @(posedge clk) begin
    if (!rst_n)    pend <= '0;
    else if (load) pend <= load_mask;
    else           pend <= pend & ~ack_valid;
  end

  assign all_done = ((pend & ~ack_valid) == '0);

  // Outside a load, the set of awaited caches can only shrink (R4).
  assert_pend_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((pend & ~$past(pend)) == '0));

endmodule

// File: rtl/coh_fsm.sv
module coh_fsm
  import coh_dir_pkg::*;
#(
  parameter int NC = 4,
  parameter int NL = 4,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] req_src,
  input  logic [LW-1:0] req_line,
  input  logic          req_excl,
  output logic          nack,
  output logic [LW-1:0] rd_line,
  input  line_st_e      rd_st,
  input  logic [NC-1:0] rd_mask,
  output logic          wr_en,
  output logic [LW-1:0] wr_line,
  output line_st_e      wr_st,
  output logic [NC-1:0] wr_mask,
  output logic          load,
  output logic [NC-1:0] load_mask,
  input  logic          all_done,
  output logic          cmd_valid,
  output logic          cmd_wb,
  output logic [NC-1:0] cmd_mask,
  output logic [LW-1:0] cmd_line,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [LW-1:0] mem_line,
  input  logic          mem_done,
  output logic          rsp_valid,
  output logic [CW-1:0] rsp_dst,
  output logic [LW-1:0] rsp_line,
  output logic [1:0]    rsp_code
);

  function automatic logic [NC-1:0] bit_of(input logic [CW-1:0] c);
    return NC'(1) << c;
  endfunction

  // First phase of a transaction from the line state and the other holders.
  function automatic phase_e entry_phase(input logic excl, input line_st_e st,
                                         input logic [NC-1:0] others);
    if (!excl) return (st == LN_EXC && others != '0) ? PH_WB : PH_MRD;
    case (st)
      LN_UNC:  return PH_MRD;
      LN_SHR:  return (others == '0) ? PH_RESP : PH_INV;
      default: return (others == '0) ? PH_RESP : PH_WB;
    endcase
  endfunction

  // Holder set written back when the grant is issued.
  function automatic logic [NC-1:0] merged_set(input logic excl, input logic [NC-1:0] cur,
                                               input logic [NC-1:0] who);
    return excl ? who : (cur | who);
  endfunction

  phase_e        ph_q, ph_d, first;
  logic [CW-1:0] src_q;
  logic [LW-1:0] line_q;
  logic          excl_q, held_q;
  logic          accept, snoop_go;
  logic [NC-1:0] others;

  assign accept   = req_valid && (ph_q == PH_IDLE);
  assign others   = rd_mask & ~bit_of(req_src);
  assign first    = entry_phase(req_excl, rd_st, others);
  assign snoop_go = accept && (first == PH_INV || first == PH_WB);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (accept)   ph_d = first;
      PH_INV:  if (all_done) ph_d = held_q ? PH_RESP : PH_MRD;
      PH_WB:   if (all_done) ph_d = PH_MWR;
      PH_MWR:  if (mem_done) ph_d = PH_RESP;
      PH_MRD:  if (mem_done) ph_d = PH_RESP;
      PH_RESP:               ph_d = PH_IDLE;
      default:               ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cmd_valid <= 1'b0;
      cmd_wb    <= 1'b0;
      cmd_mask  <= '0;
      src_q     <= '0;
      line_q    <= '0;
      excl_q    <= 1'b0;
      held_q    <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      cmd_valid <= snoop_go;
      if (accept) begin
        src_q    <= req_src;
        line_q   <= req_line;
        excl_q   <= req_excl;
        held_q   <= rd_mask[req_src];
        cmd_wb   <= (first == PH_WB);
        cmd_mask <= others;
      end
    end
  end

  assign nack      = req_valid && (ph_q != PH_IDLE);
  assign rd_line   = (ph_q == PH_IDLE) ? req_line : line_q;
  assign wr_en     = (ph_q == PH_RESP);
  assign wr_line   = line_q;
  assign wr_st     = excl_q ? LN_EXC : LN_SHR;
  assign wr_mask   = merged_set(excl_q, rd_mask, bit_of(src_q));
  assign load      = snoop_go;
  assign load_mask = others;
  assign cmd_line  = line_q;
  assign mem_rd    = (ph_q == PH_MRD);
  assign mem_wr    = (ph_q == PH_MWR);
  assign mem_line  = line_q;
  assign rsp_valid = (ph_q == PH_RESP);
  assign rsp_dst   = src_q;
  assign rsp_line  = line_q;
  assign rsp_code  = excl_q ? RSP_EXCL : RSP_SHARED;

  assert_snoop_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_grant_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_refused_keeps_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nack && !rsp_valid) |=> $stable(line_q));

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int NC = 4,
  parameter int NL = 4,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] req_src,
  input  logic [LW-1:0] req_line,
  input  logic          req_excl,
  output logic          req_nack,
  input  logic [NC-1:0] ack_valid,
  output logic          snp_valid,
  output logic          snp_wb,
  output logic [NC-1:0] snp_mask,
  output logic [LW-1:0] snp_line,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [LW-1:0] mem_line,
  input  logic          mem_done,
  output logic          rsp_valid,
  output logic [CW-1:0] rsp_dst,
  output logic [LW-1:0] rsp_line,
  output logic [1:0]    rsp_code
);

  logic [LW-1:0] rd_line, wr_line;
  line_st_e      rd_st, wr_st;
  logic [NC-1:0] rd_mask, wr_mask, load_mask, pend;
  logic          wr_en, load, all_done;

  coh_dir_store #(.NC(NC), .NL(NL)) u_store (
    .clk, .rst_n, .rd_line, .rd_st, .rd_mask,
    .wr_en, .wr_line, .wr_st, .wr_mask
  );

  coh_ack_tracker #(.NC(NC)) u_acks (
    .clk, .rst_n, .load, .load_mask, .ack_valid, .pend, .all_done
  );

  coh_fsm #(.NC(NC), .NL(NL)) u_fsm (
    .clk, .rst_n, .req_valid, .req_src, .req_line, .req_excl,
    .nack(req_nack), .rd_line, .rd_st, .rd_mask,
    .wr_en, .wr_line, .wr_st, .wr_mask, .load, .load_mask, .all_done,
    .cmd_valid(snp_valid), .cmd_wb(snp_wb), .cmd_mask(snp_mask), .cmd_line(snp_line),
    .mem_rd, .mem_wr, .mem_line, .mem_done,
    .rsp_valid, .rsp_dst, .rsp_line, .rsp_code
  );

  // No grant while any addressed cache has yet to acknowledge.
  assert_grant_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (pend == '0));
  // Memory is refreshed only after the owner confirmed its write-back.
  assert_memwr_after_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> (pend == '0));

endmodule

// File: tb/tb_coh_dir_ctrl.sv
`timescale 1ns/1ps
module tb_coh_dir_ctrl;
  localparam int NC = 4;
  localparam int NL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_src = '0;
  logic [1:0] req_line = '0;
  logic       req_excl = 1'b0;
  logic       req_nack;
  logic [3:0] ack_valid = '0;
  logic       snp_valid, snp_wb;
  logic [3:0] snp_mask;
  logic [1:0] snp_line;
  logic       mem_rd, mem_wr;
  logic [1:0] mem_line;
  logic       mem_done = 1'b0;
  logic       rsp_valid;
  logic [1:0] rsp_dst, rsp_line, rsp_code;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Behavioural directory model: 0 uncached, 1 shared, 2 owned.
  int m_st   [NL];
  int m_mask [NL];

  always #10 clk = ~clk;

  coh_dir_ctrl #(.NC(NC), .NL(NL)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet(input string req);
    chk(rsp_valid == 1'b0, req, rsp_valid, 0);
  endtask

  task automatic mem_wait(input bit is_wr, input int ln, input string req);
    for (int i = 0; i < 3; i++) begin
      if (is_wr) chk(mem_wr == 1'b1 && mem_rd == 1'b0, req, mem_wr, 1);
      else       chk(mem_rd == 1'b1 && mem_wr == 1'b0, req, mem_rd, 1);
      chk(mem_line == 2'(ln), req, mem_line, ln);
      quiet(req);
      if (i == 2) mem_done = 1'b1;
      @(negedge clk);
      mem_done = 1'b0;
    end
  endtask

  task automatic txn(input int src, input int ln, input bit ex, input bit poke);
    int  srcb, oth, st, msk;
    bit  do_inv, do_wb, do_mrd, do_mwr;
    string tag;
    srcb = 1 << src;
    st   = m_st[ln];
    msk  = m_mask[ln];
    oth  = msk & ~srcb;
    do_inv = 0; do_wb = 0; do_mrd = 0; do_mwr = 0;
    if (!ex) begin
      if (st == 2 && oth != 0) begin do_wb = 1; do_mwr = 1; tag = "R6"; end
      else begin do_mrd = 1; tag = "R2"; end
    end else if (st == 0) begin
      do_mrd = 1; tag = "R8";
    end else if (oth == 0) begin
      tag = "R3";
    end else if (st == 1) begin
      do_inv = 1; do_mrd = ((msk & srcb) == 0);
      tag = do_mrd ? "R5" : "R4";
    end else begin
      do_wb = 1; do_mwr = 1; tag = "R7";
    end

    req_valid = 1'b1; req_src = 2'(src); req_line = 2'(ln); req_excl = ex;
    #1 chk(req_nack == 1'b0, "R9 idle accept", req_nack, 0);
    @(negedge clk);
    req_valid = 1'b0;

    if (do_inv || do_wb) begin
      chk(snp_valid == 1'b1, tag, snp_valid, 1);
      chk(snp_wb == do_wb, tag, snp_wb, do_wb);
      chk(snp_mask == 4'(oth), tag, snp_mask, oth);
      chk(snp_line == 2'(ln), tag, snp_line, ln);
      quiet(tag);
      if (poke) begin
        ack_valid = 4'(srcb);                       // stray acknowledgement
        req_valid = 1'b1; req_src = 2'((src + 1) % NC); req_line = 2'(ln); req_excl = 1'b1;
        #1 chk(req_nack == 1'b1, "R9 busy refuse", req_nack, 1);
      end
      @(negedge clk);
      ack_valid = '0; req_valid = 1'b0;
      chk(snp_valid == 1'b0, "R4 snoop one cycle", snp_valid, 0);
      for (int c = 0; c < NC; c++) begin
        if (oth[c]) begin
          quiet({tag, " before all acks"});
          chk(mem_rd == 1'b0 && mem_wr == 1'b0, {tag, " no memory during wait"}, mem_rd, 0);
          ack_valid = 4'(1 << c);
          @(negedge clk);
          ack_valid = '0;
        end
      end
    end

    if (do_mwr) mem_wait(1'b1, ln, tag);
    if (do_mrd) mem_wait(1'b0, ln, tag);
    if (tag == "R3") chk(snp_valid == 1'b0 && mem_rd == 1'b0, "R3 no snoop", snp_valid, 0);

    chk(rsp_valid == 1'b1, tag, rsp_valid, 1);
    chk(rsp_dst == 2'(src), tag, rsp_dst, src);
    chk(rsp_line == 2'(ln), tag, rsp_line, ln);
    chk(rsp_code == (ex ? 2'b10 : 2'b01), tag, rsp_code, ex ? 2 : 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, {tag, " grant one cycle"}, rsp_valid, 0);

    if (ex) begin m_st[ln] = 2; m_mask[ln] = srcb; end
    else    begin m_st[ln] = 1; m_mask[ln] = msk | srcb; end
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_mask[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(rsp_valid == 0 && snp_valid == 0, "R1 reset outputs", rsp_valid, 0);
    chk(mem_rd == 0 && mem_wr == 0 && req_nack == 0, "R1 reset memory", mem_rd, 0);

    txn(0, 1, 0, 0);   // R2 uncached read
    txn(1, 1, 0, 0);   // R2 shared read
    txn(2, 1, 0, 0);   // R2 shared read, sharers 0,1,2
    txn(1, 1, 1, 1);   // R4 invalidate 0 and 2, with stray ack and refused request (R9)
    txn(3, 1, 0, 0);   // R6 read on owned line
    txn(3, 1, 1, 0);   // R4 invalidate former owner, requester held
    txn(3, 1, 1, 0);   // R3 owner asks again
    txn(2, 2, 1, 0);   // R8 uncached exclusive
    txn(0, 2, 1, 1);   // R7 takeover with refused request (R9)
    txn(1, 0, 0, 0);   // R2
    txn(1, 0, 1, 0);   // R3 sole sharer
    txn(2, 0, 0, 0);   // R6 write-back, sharers 1,2
    txn(0, 3, 0, 0);   // R2
    txn(1, 3, 0, 0);   // R2
    txn(2, 3, 1, 0);   // R5 invalidate then memory read
    txn(0, 2, 0, 0);   // R6 owner reads its own line: plain memory read (R2)
    txn(3, 1, 0, 0);   // R9: line 1 must still be owned by cache 3 (refused request dropped)

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule